// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block holds the stack pointer of a small 8-bit processor core and forms the physical stack address for every push and pop. In its default mode the pointer is one byte wide and stays inside the internal general-purpose RAM, wrapping from 0FFH back to 00H. When the extended-mode enable is set, three more pointer bits come into use. The pointer grows to 11 bits, and every address at or above 0100H falls in the internal XRAM. This gives a stack of up to 2048 bytes.

A push increments the pointer first and then presents the new value as the store address, in the same cycle. A pop presents the current pointer as the read address and decrements it at the clock edge. The core reads and writes the pointer through two special-function-register ports, one for the low byte and one for the three high bits. The stack memories and the instruction sequencing sit outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the low byte reads 07H, the high register reads 00H and extended mode plays no part until it is enabled.
- R2: A push presents pointer+1 on `memAddr` in the same cycle, and the pointer holds that value after the clock edge. The first push after reset therefore addresses 008H.
- R3: With extended mode off, the pointer is 8 bits wide. A push at 0FFH addresses 000H, a pop at 000H leaves 0FFH, and `memAddr[10:8]` stays zero.
- R4: With extended mode on, the pointer is 11 bits wide. A push at 0FFH addresses 0100H with `memSelXram`=1 (1 means XRAM, 0 means internal RAM), and a push at 7FFH addresses 000H with `memSelXram`=0.
- R5: A pop presents the current pointer on `memAddr` and then decrements it. In extended mode a pop at 0100H leaves 0FFH, and a pop at 000H leaves 7FFH.
- R6: When push and pop are both asserted in one cycle, only the push takes effect.
- R7: With no push or pop in the cycle, `lowWrEn` loads `lowWrData` into pointer bits 7:0, and `highWrEn` loads `highWrData[2:0]` into pointer bits 10:8. Both writes may occur in one cycle. A write that coincides with a push or pop is ignored.
- R8: `highRead` returns zero in bits 7:3. While extended mode is off, the high bits read 0, high writes are ignored and `memSelXram` stays 0. Turning extended mode off clears the high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushEn | input | 1 | Push strobe |
| popEn | input | 1 | Pop strobe |
| extMode | input | 1 | Selects the 11-bit extended pointer |
| lowWrEn | input | 1 | Write strobe for the low-byte register |
| lowWrData | input | 8 | Data for the low-byte register |
| highWrEn | input | 1 | Write strobe for the high register |
| highWrData | input | 8 | Data for the high register (bits 2:0 used) |
| memSelXram | output | 1 | 1 = address is in XRAM, 0 = internal RAM |
| memAddr | output | 11 | Stack access address for this cycle |
| lowRead | output | 8 | Low-byte register readback |
| highRead | output | 8 | High register readback |

## Verification
The bench drives pointers across both wrap points in each mode. A design that carried past 0FFH in default mode would leave RAM. A design that failed to carry in extended mode would fold the stack back onto the register banks. The bench also pops from 0100H and from 000H, where a wrong borrow lands in the wrong memory. It collides push with pop, and SFR writes with stack operations. A wrong priority there would move the pointer the wrong way or corrupt it. It toggles extended mode to catch high bits that survive in default mode.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef struct packed {
    logic inc;     // pre-increment for push
    logic dec;     // post-decrement for pop
    logic ldLow;   // load low byte from SFR port
    logic ldHigh;  // load high bits from SFR port
    logic wide;    // extended 11-bit pointer active
  } spCtrl_t;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
(
  input  logic    pushEn,
  input  logic    popEn,
  input  logic    extMode,
  input  logic    lowWrEn,
  input  logic    highWrEn,
  output spCtrl_t ctrl
);
  logic stackOp;

  always_comb begin
    stackOp     = pushEn | popEn;
    ctrl.wide   = extMode;
    ctrl.inc    = pushEn;
    ctrl.dec    = popEn & ~pushEn;
    ctrl.ldLow  = lowWrEn & ~stackOp;
    ctrl.ldHigh = highWrEn & extMode & ~stackOp;
  end
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int LOW_W     = 8,
  parameter int HIGH_W    = 3,
  parameter int RESET_VAL = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  spCtrl_t                  ctrl,
  input  logic [LOW_W-1:0]         lowData,
  input  logic [LOW_W-1:0]         highData,
  output logic                     memSelXram,
  output logic [LOW_W+HIGH_W-1:0]  memAddr,
  output logic [LOW_W-1:0]         lowRead,
  output logic [LOW_W-1:0]         highRead
);
  localparam int PTR_W = LOW_W + HIGH_W;
  localparam logic [PTR_W-1:0] RAM_TOP  = PTR_W'((1 << LOW_W) - 1);
  localparam logic [PTR_W-1:0] XRAM_BOT = PTR_W'(1 << LOW_W);
  localparam logic [PTR_W-1:0] PTR_MAX  = {PTR_W{1'b1}};

  logic [PTR_W-1:0] ptrQ, ptrD, effPtr, incFull, decFull, incVal, decVal;

  always_comb begin
    effPtr  = ctrl.wide ? ptrQ : {{HIGH_W{1'b0}}, ptrQ[LOW_W-1:0]};
    incFull = effPtr + PTR_W'(1);
    decFull = effPtr - PTR_W'(1);
    incVal  = ctrl.wide ? incFull : {{HIGH_W{1'b0}}, incFull[LOW_W-1:0]};
    decVal  = ctrl.wide ? decFull : {{HIGH_W{1'b0}}, decFull[LOW_W-1:0]};
  end

  always_comb begin
    ptrD = effPtr;
    if (ctrl.inc) begin
      ptrD = incVal;
    end else if (ctrl.dec) begin
      ptrD = decVal;
    end else begin
      if (ctrl.ldLow)  ptrD[LOW_W-1:0]     = lowData;
      if (ctrl.ldHigh) ptrD[PTR_W-1:LOW_W] = highData[HIGH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptrQ <= PTR_W'(RESET_VAL);
    else       ptrQ <= ptrD;
  end

  always_comb begin
    memAddr    = ctrl.inc ? incVal : effPtr;
    memSelXram = |memAddr[PTR_W-1:LOW_W];
    lowRead    = effPtr[LOW_W-1:0];
    highRead   = {{(LOW_W-HIGH_W){1'b0}}, effPtr[PTR_W-1:LOW_W]};
  end

  // R2
  push_preinc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.inc |=> ptrQ == $past(memAddr));

  // R3
  narrow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.inc && !ctrl.wide && effPtr == RAM_TOP) |=> ptrQ == '0);

  // R4
  wide_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.inc && ctrl.wide && effPtr == RAM_TOP) |-> (memSelXram && memAddr == XRAM_BOT));

  // R5
  pop_borrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.dec && ctrl.wide && effPtr == XRAM_BOT) |=> ptrQ == RAM_TOP);

  // R5
  pop_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.dec && ctrl.wide && effPtr == '0) |=> ptrQ == PTR_MAX);

  // R8
  narrow_ram_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wide |-> (!memSelXram && highRead == '0));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int LOW_W     = 8,
  parameter int HIGH_W    = 3,
  parameter int RESET_VAL = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pushEn,
  input  logic                    popEn,
  input  logic                    extMode,
  input  logic                    lowWrEn,
  input  logic [LOW_W-1:0]        lowWrData,
  input  logic                    highWrEn,
  input  logic [LOW_W-1:0]        highWrData,
  output logic                    memSelXram,
  output logic [LOW_W+HIGH_W-1:0] memAddr,
  output logic [LOW_W-1:0]        lowRead,
  output logic [LOW_W-1:0]        highRead
);
  spCtrl_t ctrl;

  sp_ctrl uCtrl (
    .pushEn   (pushEn),
    .popEn    (popEn),
    .extMode  (extMode),
    .lowWrEn  (lowWrEn),
    .highWrEn (highWrEn),
    .ctrl     (ctrl)
  );

  sp_datapath #(
    .LOW_W     (LOW_W),
    .HIGH_W    (HIGH_W),
    .RESET_VAL (RESET_VAL)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .lowData    (lowWrData),
    .highData   (highWrData),
    .memSelXram (memSelXram),
    .memAddr    (memAddr),
    .lowRead    (lowRead),
    .highRead   (highRead)
  );
endmodule

// File: tb/tb_stack_ptr_unit.sv
`timescale 1ns/100ps
module tb_stack_ptr_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        pushEn = 0, popEn = 0, extMode = 0;
  logic        lowWrEn = 0, highWrEn = 0;
  logic [7:0]  lowWrData = 0, highWrData = 0;
  logic        memSelXram;
  logic [10:0] memAddr;
  logic [7:0]  lowRead, highRead;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct {
    int    addr;
    int    sel;
    int    low;
    int    high;
    string tag;
  } item_t;
  item_t expQ[$];

  int modelPtr = 7;

  always #2 clk = ~clk;

  stack_ptr_unit dut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn), .extMode(extMode),
    .lowWrEn(lowWrEn), .lowWrData(lowWrData), .highWrEn(highWrEn),
    .highWrData(highWrData), .memSelXram(memSelXram), .memAddr(memAddr),
    .lowRead(lowRead), .highRead(highRead)
  );

  // driver: one cycle of stimulus plus its expected outputs
  task automatic step(input bit push, input bit pop, input bit ext,
                      input bit lw, input int ld, input bit hw, input int hd,
                      input string tag);
    item_t it;
    int eff, nxt, a;
    @(posedge clk);
    #1;
    pushEn = push; popEn = pop; extMode = ext;
    lowWrEn = lw; lowWrData = 8'(ld); highWrEn = hw; highWrData = 8'(hd);
    eff = ext ? modelPtr : (modelPtr & 'hFF);
    a = push ? (ext ? ((eff + 1) & 'h7FF) : ((eff + 1) & 'hFF)) : eff;
    it.addr = a;
    it.sel  = (a >= 'h100) ? 1 : 0;
    it.low  = eff & 'hFF;
    it.high = eff >> 8;
    it.tag  = tag;
    expQ.push_back(it);
    nxt = eff;
    if (push) nxt = a;
    else if (pop) nxt = ext ? ((eff - 1) & 'h7FF) : ((eff - 1) & 'hFF);
    else begin
      if (lw) nxt = (nxt & 'h700) | (ld & 'hFF);
      if (hw && ext) nxt = (nxt & 'hFF) | ((hd & 7) << 8);
    end
    modelPtr = nxt;
  endtask

  // monitor: compares between clock edges
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      checks++;
      if (int'(memAddr) != e.addr || int'(memSelXram) != e.sel ||
          int'(lowRead) != e.low || int'(highRead) != e.high) begin
        fails++;
        $display("FAIL %s: addr=%03h sel=%0d low=%02h high=%02h expected addr=%03h sel=%0d low=%02h high=%02h",
                 e.tag, memAddr, memSelXram, lowRead, highRead, e.addr, e.sel, e.low, e.high);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset values
    step(0,0,0, 0,0, 0,0, "R1");
    // R2 pre-increment push
    step(1,0,0, 0,0, 0,0, "R2");
    step(1,0,0, 0,0, 0,0, "R2");
    // R5 pop then decrement
    step(0,1,0, 0,0, 0,0, "R5");
    // R3 default wrap
    step(0,0,0, 1,'hFF, 0,0, "R7");
    step(1,0,0, 0,0, 0,0, "R3");
    step(0,1,0, 0,0, 0,0, "R3");
    // R8 high write ignored in default mode
    step(0,0,0, 0,0, 1,5, "R8");
    step(0,0,0, 0,0, 0,0, "R8");
    // R4 extended carry
    step(0,0,1, 1,'hFF, 1,0, "R7");
    step(1,0,1, 0,0, 0,0, "R4");
    step(0,1,1, 0,0, 0,0, "R5");
    step(0,1,1, 0,0, 0,0, "R5");
    // R8 upper bits of high register read zero
    step(0,0,1, 1,'hFF, 1,'hFF, "R8");
    step(1,0,1, 0,0, 0,0, "R4");
    step(0,1,1, 0,0, 0,0, "R5");
    // R6 push wins
    step(1,1,1, 0,0, 0,0, "R6");
    step(0,0,1, 0,0, 0,0, "R6");
    // R7 write during pop ignored
    step(0,1,1, 1,'h40, 1,2, "R7");
    step(0,0,1, 0,0, 0,0, "R7");
    step(0,0,1, 1,'h10, 1,3, "R7");
    step(0,0,1, 0,0, 0,0, "R7");
    // R8 leaving extended mode clears high bits
    step(0,0,0, 0,0, 0,0, "R8");
    step(0,0,1, 0,0, 0,0, "R8");
    // R4 pushes across the RAM/XRAM boundary
    step(0,0,1, 1,'hFD, 1,0, "R7");
    for (int i = 0; i < 5; i++) step(1,0,1, 0,0, 0,0, "R4");
    for (int i = 0; i < 5; i++) step(0,1,1, 0,0, 0,0, "R5");
    // R3 default-mode pushes across the wrap
    step(0,0,0, 1,'hFE, 0,0, "R7");
    for (int i = 0; i < 4; i++) step(1,0,0, 0,0, 0,0, "R3");
    step(0,0,0, 0,0, 0,0, "R3");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule